// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns one 64-bit virtual address into a physical address for a single access. A request carries the address, the permission the access needs (read, write or execute, one-hot) and a privilege index. Two cases finish without touching memory: a physical privilege index passes the address straight through, and a kernel direct-mapped window is relocated by fixed bit moves. Every other canonical address is resolved by reading three levels of page table entries through a 64-bit read port, starting at a table base input.

The walker handles one request at a time. It accepts a request only when idle, issues at most one table read at a time, and returns the physical address, a permission mask and a fault code. The fault code is zero on success. The result is marked by a one-cycle valid pulse and stays on the outputs until the next request is accepted. Caching of translations, bus error handling and trap delivery belong to the surrounding logic.

Top module: `ptw_walker`

## Requirements
- R1: Privilege index 2 (physical) returns the input address unchanged, permission mask 3'b111 and fault 0, and issues no memory read.
- R2: For the other indices, if address bits [63:43] are not all equal to bit 63, the result is fault 2 (access violation) and no memory read is issued.
- R3: A canonical address with bit 63 set and bits [42:41] equal to 2'b10 is the kernel window. Index 0 (kernel) gets address bits [39:0], with address bit 40 placed at physical bit 43 and all other bits zero, mask 3'b111 and fault 0. Any other index gets fault 2. No memory read is issued in either case.
- R4: The walk reads the first entry at base input + 8*va[42:33], the second at T1 + 8*va[32:23] and the third at T2 + 8*va[22:13]. T1 and T2 are entry bits [63:32] shifted left by 13. On success the physical address is third-entry bits [63:32] shifted left by 13, ORed with va[12:0].
- R5: An entry with bit 0 (valid) clear, at any level, ends the walk with fault 1 (translation not valid). No further reads are issued.
- R6: A valid first- or second-level entry with bit 8 clear ends the walk with fault 2.
- R7: In the third entry, bit 8+index grants read and execute, and bit 12+index grants write. The mask uses bit 0 for read, bit 1 for write and bit 2 for execute. If a permission is needed and none of it is granted, the fault is 2.
- R8: Third-entry bits 1, 2 and 3 withdraw read, write and execute respectively, and the reported mask is what remains. If the needed permission is withdrawn, the fault is 5 for execute, else 4 for write, else 3 for read.
- R9: Fault code 0 means success, and on success the reported mask always contains the needed permission.
- R10: A read request is held, with a stable address, until it is acknowledged. No new read request is issued between an acknowledge and its data response.
- R11: The ready output is high only while the walker is idle. The result valid pulse lasts one cycle, and the address, mask and fault outputs hold their values after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ptbr_i | input | 64 | First-level table base address |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_va_i | input | 64 | Virtual address |
| req_need_i | input | 3 | Needed permission, one-hot: bit0 read, bit1 write, bit2 execute |
| req_priv_i | input | 2 | Privilege index: 0 kernel, 1 user, 2 physical |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 64 | Table entry address |
| mem_ack_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table entry read data |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_pa_o | output | 64 | Physical address |
| res_prot_o | output | 3 | Permission mask |
| res_fault_o | output | 3 | Fault code: 0 ok, 1 not valid, 2 violation, 3/4/5 fault on read/write/execute |

## Verification
The assertions assume a well-behaved memory side. Data responses arrive only after a read was acknowledged, exactly one response arrives per acknowledge, and the acknowledge is raised only while a request is visible. They also assume the privilege index never takes the value 3 and the needed permission has at most one bit set. The bench memory responder acknowledges only a visible request and returns a single response two cycles later, and every request the bench drives uses indices 0 to 2 and a one-hot permission.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int DEF_VA_BITS   = 43;
    localparam int DEF_PAGE_BITS = 13;
    localparam int DEF_IDX_BITS  = 10;
    localparam int WALK_LEVELS   = 3;
    localparam int ENTRY_SHIFT   = 3;

    localparam int PTE_V_BIT     = 0;
    localparam int PTE_FO_LSB    = 1;
    localparam int PTE_RE_LSB    = 8;
    localparam int PTE_WE_LSB    = 12;
    localparam int PTE_PFN_LSB   = 32;

    localparam int KWIN_TAG_LSB  = 41;
    localparam logic [1:0] KWIN_TAG = 2'b10;
    localparam int KWIN_SPAN     = 40;
    localparam int KWIN_RELOC    = 43;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    localparam logic [1:0] PRIV_KERN = 2'd0;
    localparam logic [1:0] PRIV_PHYS = 2'd2;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_TNV  = 3'd1,
        FLT_ACV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1, ST_L2, ST_L3, ST_DONE
    } walk_st_e;

    typedef struct packed {
        walk_st_e    st;
        logic        waiting;
        logic [63:0] va;
        logic [2:0]  need;
        logic [1:0]  priv;
        logic [63:0] base;
        logic [63:0] pa;
        logic [2:0]  prot;
        fault_e      fault;
    } walk_regs_t;
endpackage

// File: rtl/ptw_region.sv
module ptw_region
    import ptw_pkg::*;
#(
    parameter int VA_BITS = DEF_VA_BITS
) (
    input  logic [63:0] va_i,
    input  logic [1:0]  priv_i,
    output logic        hit_o,
    output logic [63:0] pa_o,
    output logic [2:0]  prot_o,
    output fault_e      fault_o
);
    localparam int HI_W = 64 - VA_BITS;

    logic canon;
    logic kwin;

    always_comb begin
        canon   = (va_i[63:VA_BITS] == {HI_W{va_i[63]}});
        kwin    = va_i[63] && (va_i[KWIN_TAG_LSB +: 2] == KWIN_TAG);
        hit_o   = 1'b0;
        pa_o    = '0;
        prot_o  = '0;
        fault_o = FLT_NONE;
        if (priv_i == PRIV_PHYS) begin
            hit_o  = 1'b1;
            pa_o   = va_i;
            prot_o = 3'b111;
        end else if (!canon) begin
            hit_o   = 1'b1;
            fault_o = FLT_ACV;
        end else if (kwin) begin
            hit_o = 1'b1;
            if (priv_i != PRIV_KERN) begin
                fault_o = FLT_ACV;
            end else begin
                pa_o   = 64'(va_i[KWIN_SPAN-1:0]) | (64'(va_i[KWIN_SPAN]) << KWIN_RELOC);
                prot_o = 3'b111;
            end
        end
    end
endmodule

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
#(
    parameter int PAGE_BITS = DEF_PAGE_BITS,
    parameter int IDX_BITS  = DEF_IDX_BITS,
    parameter int LEVELS    = WALK_LEVELS,
    localparam int LVL_W    = $clog2(LEVELS)
) (
    input  logic [63:0]      base_i,
    input  logic [63:0]      va_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [63:0]      addr_o
);
    logic [IDX_BITS-1:0] field [LEVELS];
    logic unused_va;

    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign field[g] = va_i[PAGE_BITS + IDX_BITS*(LEVELS-1-g) +: IDX_BITS];
    end

    assign unused_va = ^va_i;
    assign addr_o    = base_i + (64'(field[level_i]) << ENTRY_SHIFT);
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int PAGE_BITS = DEF_PAGE_BITS
) (
    input  logic [63:0]          pte_i,
    input  logic                 leaf_i,
    input  logic [PAGE_BITS-1:0] off_i,
    input  logic [2:0]           need_i,
    input  logic [1:0]           priv_i,
    output fault_e               fault_o,
    output logic [63:0]          next_base_o,
    output logic [63:0]          pa_o,
    output logic [2:0]           prot_o
);
    logic       rd_en;
    logic       wr_en;
    logic [2:0] granted;
    logic [2:0] kept;
    logic       unused_pte;

    assign unused_pte = ^pte_i;

    always_comb begin
        next_base_o = 64'(pte_i[63:PTE_PFN_LSB]) << PAGE_BITS;
        rd_en       = pte_i[PTE_RE_LSB + int'(priv_i)];
        wr_en       = pte_i[PTE_WE_LSB + int'(priv_i)];
        granted     = {rd_en, wr_en, rd_en};
        kept        = granted & ~pte_i[PTE_FO_LSB +: 3];
        pa_o        = '0;
        prot_o      = '0;
        fault_o     = FLT_NONE;
        if (!pte_i[PTE_V_BIT]) begin
            fault_o = FLT_TNV;
        end else if (!leaf_i) begin
            if (!pte_i[PTE_RE_LSB]) fault_o = FLT_ACV;
        end else begin
            pa_o = next_base_o | 64'(off_i);
            if (need_i != 3'b000 && (granted & need_i) == 3'b000) begin
                fault_o = FLT_ACV;
                prot_o  = granted;
            end else begin
                prot_o = kept;
                if (need_i != 3'b000 && (kept & need_i) == 3'b000) begin
                    fault_o = need_i[PERM_X] ? FLT_FOE :
                              need_i[PERM_W] ? FLT_FOW : FLT_FOR;
                end
            end
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_BITS   = DEF_VA_BITS,
    parameter int PAGE_BITS = DEF_PAGE_BITS,
    parameter int IDX_BITS  = DEF_IDX_BITS
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [63:0] ptbr_i,
    input  logic        req_valid_i,
    output logic        req_ready_o,
    input  logic [63:0] req_va_i,
    input  logic [2:0]  req_need_i,
    input  logic [1:0]  req_priv_i,
    output logic        mem_req_o,
    output logic [63:0] mem_addr_o,
    input  logic        mem_ack_i,
    input  logic        mem_rvalid_i,
    input  logic [63:0] mem_rdata_i,
    output logic        res_valid_o,
    output logic [63:0] res_pa_o,
    output logic [2:0]  res_prot_o,
    output logic [2:0]  res_fault_o
);
    localparam int LVL_W = $clog2(WALK_LEVELS);

    walk_regs_t q, d;

    logic             rg_hit;
    logic [63:0]      rg_pa;
    logic [2:0]       rg_prot;
    fault_e           rg_fault;
    logic [LVL_W-1:0] level;
    logic             is_leaf;
    fault_e           ev_fault;
    logic [63:0]      ev_next;
    logic [63:0]      ev_pa;
    logic [2:0]       ev_prot;

    ptw_region #(.VA_BITS(VA_BITS)) i_region (
        .va_i    (req_va_i),
        .priv_i  (req_priv_i),
        .hit_o   (rg_hit),
        .pa_o    (rg_pa),
        .prot_o  (rg_prot),
        .fault_o (rg_fault)
    );

    assign level   = (q.st == ST_L1) ? LVL_W'(0) : (q.st == ST_L2) ? LVL_W'(1) : LVL_W'(2);
    assign is_leaf = (q.st == ST_L3);

    ptw_index #(
        .PAGE_BITS (PAGE_BITS),
        .IDX_BITS  (IDX_BITS),
        .LEVELS    (WALK_LEVELS)
    ) i_index (
        .base_i  (q.base),
        .va_i    (q.va),
        .level_i (level),
        .addr_o  (mem_addr_o)
    );

    ptw_pte_eval #(.PAGE_BITS(PAGE_BITS)) i_eval (
        .pte_i       (mem_rdata_i),
        .leaf_i      (is_leaf),
        .off_i       (q.va[PAGE_BITS-1:0]),
        .need_i      (q.need),
        .priv_i      (q.priv),
        .fault_o     (ev_fault),
        .next_base_o (ev_next),
        .pa_o        (ev_pa),
        .prot_o      (ev_prot)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.va      = req_va_i;
                    d.need    = req_need_i;
                    d.priv    = req_priv_i;
                    d.base    = ptbr_i;
                    d.waiting = 1'b0;
                    if (rg_hit) begin
                        d.pa    = rg_pa;
                        d.prot  = rg_prot;
                        d.fault = rg_fault;
                        d.st    = ST_DONE;
                    end else begin
                        d.st = ST_L1;
                    end
                end
            end
            ST_L1, ST_L2, ST_L3: begin
                if (!q.waiting) begin
                    if (mem_ack_i) d.waiting = 1'b1;
                end else if (mem_rvalid_i) begin
                    d.waiting = 1'b0;
                    if (ev_fault != FLT_NONE || is_leaf) begin
                        d.pa    = ev_pa;
                        d.prot  = ev_prot;
                        d.fault = ev_fault;
                        d.st    = ST_DONE;
                    end else begin
                        d.base = ev_next;
                        d.st   = (q.st == ST_L1) ? ST_L2 : ST_L3;
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign req_ready_o = (q.st == ST_IDLE);
    assign mem_req_o   = (q.st == ST_L1 || q.st == ST_L2 || q.st == ST_L3) && !q.waiting;
    assign res_valid_o = (q.st == ST_DONE);
    assign res_pa_o    = q.pa;
    assign res_prot_o  = q.prot;
    assign res_fault_o = q.fault;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_valid_i,
    input logic        req_ready_o,
    input logic [2:0]  req_need_i,
    input logic [1:0]  req_priv_i,
    input logic        mem_req_o,
    input logic [63:0] mem_addr_o,
    input logic        mem_ack_i,
    input logic        res_valid_o,
    input logic [2:0]  res_prot_o,
    input logic [2:0]  res_fault_o
);
    a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r10_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_ack_i) |=> !mem_req_o);

    a_r11_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |=> !res_valid_o);

    a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> !mem_req_o);

    a_r1_phys_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && req_priv_i == 2'd2)
        |=> (res_valid_o && res_fault_o == 3'd0 && res_prot_o == 3'b111));

    a_r9_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> (res_fault_o <= 3'd5));

    a_r9_ok_has_perm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && req_need_i == 3'b000 && req_priv_i == 2'd2)
        |=> res_fault_o == 3'd0);
endmodule

bind ptw_walker ptw_walker_chk i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_need_i  (req_need_i),
    .req_priv_i  (req_priv_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .res_valid_o (res_valid_o),
    .res_prot_o  (res_prot_o),
    .res_fault_o (res_fault_o)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ptbr = 64'h10000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [2:0]  req_need = '0;
    logic [1:0]  req_priv = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        res_valid;
    logic [63:0] res_pa;
    logic [2:0]  res_prot;
    logic [2:0]  res_fault;

    always #5 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk_i (clk), .rst_ni (rst_n), .ptbr_i (ptbr),
        .req_valid_i (req_valid), .req_ready_o (req_ready),
        .req_va_i (req_va), .req_need_i (req_need), .req_priv_i (req_priv),
        .mem_req_o (mem_req), .mem_addr_o (mem_addr), .mem_ack_i (mem_ack),
        .mem_rvalid_i (mem_rvalid), .mem_rdata_i (mem_rdata),
        .res_valid_o (res_valid), .res_pa_o (res_pa),
        .res_prot_o (res_prot), .res_fault_o (res_fault)
    );

    typedef struct {
        logic [63:0] pa;
        logic [2:0]  prot;
        logic [2:0]  fault;
        int          reads;
        int          reads0;
        string       tag;
    } exp_t;

    logic [63:0] pt_mem [logic [63:0]];
    exp_t        sb [$];
    int          n_checks = 0;
    int          n_err = 0;
    int          n_reads = 0;
    logic        have_pend = 1'b0;
    logic [63:0] cap_addr = '0;

    function automatic logic [63:0] rd(input logic [63:0] a);
        return pt_mem.exists(a) ? pt_mem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] va_of(input int l1, input int l2, input int l3, input int off);
        return (64'(l1) << 33) | (64'(l2) << 23) | (64'(l3) << 13) | 64'(off);
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [63:0] va, input logic [2:0] need, input logic [1:0] priv);
        exp_t e;
        logic [63:0] base, pte;
        logic [2:0] g, k;
        e.pa = '0; e.prot = '0; e.fault = '0; e.reads = 0; e.reads0 = 0; e.tag = "";
        pte = '0;
        if (priv == 2'd2) begin e.pa = va; e.prot = 3'b111; return e; end
        if (va[63:43] != {21{va[63]}}) begin e.fault = 3'd2; return e; end
        if (va[63] && va[42:41] == 2'b10) begin
            if (priv != 2'd0) e.fault = 3'd2;
            else begin e.pa = {20'd0, va[40], 3'd0, va[39:0]}; e.prot = 3'b111; end
            return e;
        end
        base = ptbr;
        for (int lv = 0; lv < 3; lv++) begin
            pte = rd(base + (((va >> (13 + 10*(2-lv))) & 64'h3ff) << 3));
            e.reads++;
            if (!pte[0]) begin e.fault = 3'd1; return e; end
            if (lv < 2) begin
                if (!pte[8]) begin e.fault = 3'd2; return e; end
                base = {19'd0, pte[63:32], 13'd0};
            end
        end
        g = {pte[8+priv], pte[12+priv], pte[8+priv]};
        if (need != 0 && (g & need) == 0) begin e.fault = 3'd2; return e; end
        k = g & ~pte[3:1];
        if (need != 0 && (k & need) == 0) begin
            e.fault = need[2] ? 3'd5 : need[1] ? 3'd4 : 3'd3;
            return e;
        end
        e.pa = {19'd0, pte[63:32], 13'd0} | {51'd0, va[12:0]};
        e.prot = k;
        return e;
    endfunction

    // memory responder: ack one cycle, data two cycles after the handshake
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_ack) begin
                mem_ack = 1'b0;
                have_pend = 1'b1;
            end else if (have_pend) begin
                mem_rvalid = 1'b1;
                mem_rdata = rd(cap_addr);
                have_pend = 1'b0;
            end else if (mem_req && rst_n) begin
                mem_ack = 1'b1;
                cap_addr = mem_addr;
                n_reads++;
            end
        end
    end

    // monitor: pop expected item on each result pulse
    initial begin
        exp_t e;
        logic [63:0] pa_seen;
        logic [2:0] f_seen;
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                if (sb.size() == 0) begin
                    chk("R11", "unexpected result", 64'd1, 64'd0);
                end else begin
                    e = sb.pop_front();
                    chk(e.tag, "fault", 64'(res_fault), 64'(e.fault));
                    chk(e.tag, "reads", 64'(n_reads - e.reads0), 64'(e.reads));
                    if (e.fault == 3'd0) begin
                        chk(e.tag, "pa", res_pa, e.pa);
                        chk(e.tag, "prot", 64'(res_prot), 64'(e.prot));
                    end
                    pa_seen = res_pa;
                    f_seen = res_fault;
                    @(negedge clk);
                    chk("R11", "pulse ends", 64'(res_valid), 64'd0);
                    chk("R11", "pa held", res_pa, pa_seen);
                    chk("R11", "fault held", 64'(res_fault), 64'(f_seen));
                end
            end
        end
    end

    task automatic run(input logic [63:0] va, input logic [2:0] need, input logic [1:0] priv, input string tag);
        exp_t e;
        e = model(va, need, priv);
        e.tag = tag;
        while (!req_ready) @(negedge clk);
        e.reads0 = n_reads;
        sb.push_back(e);
        req_va = va; req_need = need; req_priv = priv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        // table setup: L1 idx1 -> L2 table 0x40000, L2 idx2 -> L3 table 0x60000
        pt_mem[64'h10008] = (64'h20 << 32) | 64'h101;
        pt_mem[64'h10030] = (64'h20 << 32) | 64'h001;
        pt_mem[64'h40010] = (64'h30 << 32) | 64'h101;
        pt_mem[64'h40038] = (64'h30 << 32) | 64'h001;
        pt_mem[64'h60018] = (64'hABCDE << 32) | 64'h0101;
        pt_mem[64'h60020] = (64'hABCDE << 32) | 64'h2201;
        pt_mem[64'h60028] = (64'hABCDE << 32) | 64'h1101;
        pt_mem[64'h60038] = (64'hABCDE << 32) | 64'h1103;
        pt_mem[64'h60040] = (64'hABCDE << 32) | 64'h1105;
        pt_mem[64'h60048] = (64'hABCDE << 32) | 64'h1109;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "ready after reset", 64'(req_ready), 64'd1);
        chk("R11", "no result after reset", 64'(res_valid), 64'd0);
        chk("R10", "no read after reset", 64'(mem_req), 64'd0);

        run(64'hDEAD_BEEF_0000_1234, 3'b010, 2'd2, "R1 physical");
        run(64'h0000_1000_0000_0000, 3'b001, 2'd0, "R2 non-canonical positive");
        run(64'h8000_0000_0000_0000, 3'b001, 2'd0, "R2 non-canonical negative");
        run(64'hFFFF_FD00_0001_2345, 3'b010, 2'd0, "R3 kernel window");
        run(64'hFFFF_FC00_0000_0777, 3'b001, 2'd0, "R3 kernel window bit40 clear");
        run(64'hFFFF_FD00_0001_2345, 3'b001, 2'd1, "R3 user in kernel window");
        run(va_of(1, 2, 3, 12'h123), 3'b001, 2'd0, "R4 kernel read walk");
        run(va_of(1, 2, 4, 12'hFFF), 3'b010, 2'd1, "R7 user write granted");
        run(va_of(1, 2, 4, 12'h010), 3'b001, 2'd0, "R7 kernel read on user page");
        run(va_of(1, 2, 5, 12'h000), 3'b001, 2'd1, "R7 user read on kernel page");
        run(va_of(1, 2, 3, 12'h008), 3'b010, 2'd0, "R7 write not granted");
        run(va_of(1, 2, 7, 12'h004), 3'b001, 2'd0, "R8 fault on read");
        run(va_of(1, 2, 7, 12'h004), 3'b010, 2'd0, "R8 write past read fault");
        run(va_of(1, 2, 8, 12'h020), 3'b010, 2'd0, "R8 fault on write");
        run(va_of(1, 2, 9, 12'h030), 3'b100, 2'd0, "R8 fault on execute");
        run(va_of(1, 2, 9, 12'h030), 3'b001, 2'd0, "R9 read past execute fault");
        run(va_of(1, 2, 10, 12'h000), 3'b001, 2'd0, "R5 leaf not valid");
        run(va_of(5, 0, 0, 12'h000), 3'b001, 2'd0, "R5 first level not valid");
        run(va_of(1, 8, 0, 12'h000), 3'b001, 2'd0, "R5 second level not valid");
        run(va_of(6, 2, 3, 12'h000), 3'b001, 2'd0, "R6 first level no kernel read");
        run(va_of(1, 7, 3, 12'h000), 3'b001, 2'd0, "R6 second level no kernel read");
        ptbr = 64'h10000 - 64'h8;
        run(va_of(2, 2, 3, 12'h055), 3'b100, 2'd0, "R4 base from input");
        ptbr = 64'h10000;

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule